// File: doc/BRIEF.md
# Top-Four Ranked Candidate Sorter

Twelve upstream processors each send up to three track candidates per bunch crossing, giving 36 fixed input slots. Each candidate has a valid bit, a 7-bit rank and a 16-bit opaque payload. On every clock the sorter picks the four candidates with the highest rank. It drives them onto four output slots with the best in slot 0.

Each output slot also carries the 6-bit index of the input that won it. The sorter returns one winner flag per input, so every source can see which of its candidates went forward. The block is fully pipelined: it accepts a new crossing every cycle and has a fixed three-cycle latency.

Top module: `rank_top4_sorter`

## Requirements
- R1: Input i (0..35) belongs to source i/3 and is candidate i%3 of that source. Its rank is at bits [7i+6:7i] of the rank bus, its payload at bits [16i+15:16i] of the payload bus, and its valid at bit i of the valid bus.
- R2: A candidate is eligible only when its valid bit is 1 and its rank is nonzero. An ineligible candidate is never placed on an output slot and never gets a winner flag.
- R3: The eligible candidates with the four highest ranks are selected. When fewer than four are eligible, all of them are selected.
- R4: Selected candidates fill output slots from slot 0 upward in non-increasing rank order, so the valid slots are contiguous from slot 0.
- R5: Among equal ranks, the lower input index is placed first. This orders by lower source, then by lower candidate within the source.
- R6: A valid output slot s carries the winning candidate's rank at bits [7s+6:7s], its input index at bits [6s+5:6s] and its payload at bits [16s+15:16s].
- R7: An output slot with no selected candidate has valid 0 and rank, index and payload all zero.
- R8: Winner bit i is 1 exactly when input i is on one of the output slots. Winner bits appear in the same cycle as the sorted outputs of that crossing.
- R9: Inputs presented in cycle c produce outputs and winner bits in cycle c+3. A new crossing is accepted every cycle.
- R10: While synchronous reset is high, every output valid and every winner bit is cleared at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 36 | Valid bit per input candidate |
| inRank | input | 252 | Packed 7-bit ranks, input 0 in the low bits |
| inPayload | input | 576 | Packed 16-bit payloads, input 0 in the low bits |
| outValid | output | 4 | Valid per output slot, slot 0 best |
| outRank | output | 28 | Packed 7-bit ranks of the output slots |
| outIndex | output | 24 | Packed 6-bit source input index per output slot |
| outPayload | output | 64 | Packed 16-bit payloads of the output slots |
| winner | output | 36 | Per-input selected flag, aligned with the outputs |

## Verification
The assertions check the following on every cycle:
- each slot's selection strobe picks at most one input;
- valid slots are contiguous from slot 0 and their ranks do not increase;
- no valid slot has rank zero and empty slots are all zero;
- the number of winner flags equals the number of valid slots;
- reset clears the outputs.

Only the bench scenarios can show the rest. These are that the chosen four really are the best, that tie order follows the input index, that payloads and indices travel with the right candidate, and that each crossing appears exactly three cycles later. The bench covers them with directed ties, an all-equal field, ineligible high ranks, a single candidate on the last input, and a long run of random back-to-back crossings.

// File: rtl/rts_pkg.sv
`timescale 1ns/1ps
package rts_pkg;
  localparam int NUM_SRC  = 12;
  localparam int PER_SRC  = 3;
  localparam int NUM_IN   = NUM_SRC * PER_SRC;
  localparam int RANK_W   = 7;
  localparam int PAY_W    = 16;
  localparam int SLOTS    = 4;
  localparam int IDX_W    = $clog2(NUM_IN);

  // strobes from control to datapath: per-slot one-hot pick over inputs
  typedef struct packed {
    logic [SLOTS-1:0][NUM_IN-1:0] pick;
    logic [SLOTS-1:0]             live;
  } sel_t;
endpackage

// File: rtl/rts_ctrl.sv
`timescale 1ns/1ps
module rts_ctrl
  import rts_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_IN-1:0]              s1Elig,
  input  logic [NUM_IN-1:0][RANK_W-1:0]  s1Rank,
  output sel_t                           selQ
);
  sel_t selD;

  // position of each input = count of eligible inputs that beat it
  always_comb begin
    selD = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      logic [IDX_W:0] pos;
      pos = '0;
      for (int j = 0; j < NUM_IN; j++) begin
        if (j != i && s1Elig[j] &&
            ((s1Rank[j] > s1Rank[i]) || (s1Rank[j] == s1Rank[i] && j < i)))
          pos = pos + 1'b1;
      end
      for (int s = 0; s < SLOTS; s++)
        selD.pick[s][i] = s1Elig[i] && (pos == (IDX_W+1)'(s));
    end
    for (int s = 0; s < SLOTS; s++)
      selD.live[s] = |selD.pick[s];
  end

  always_ff @(posedge clk) begin
    if (rst) selQ <= '0;
    else     selQ <= selD;
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
      a_r3_single_pick : assert property (@(posedge clk) disable iff (rst)
        $onehot0(selQ.pick[s]));
      a_r3_live_match : assert property (@(posedge clk) disable iff (rst)
        selQ.live[s] == (selQ.pick[s] != '0));
    end
    for (genvar s = 0; s + 1 < SLOTS; s++) begin : g_fill
      a_r4_fill_order : assert property (@(posedge clk) disable iff (rst)
        selQ.live[s+1] |-> selQ.live[s]);
    end
  endgenerate
endmodule

// File: rtl/rts_datapath.sv
`timescale 1ns/1ps
module rts_datapath
  import rts_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_IN-1:0]              inValid,
  input  logic [NUM_IN*RANK_W-1:0]       inRank,
  input  logic [NUM_IN*PAY_W-1:0]        inPayload,
  input  sel_t                           selQ,
  output logic [NUM_IN-1:0]              s1Elig,
  output logic [NUM_IN-1:0][RANK_W-1:0]  s1Rank,
  output logic [SLOTS-1:0]               outValid,
  output logic [SLOTS*RANK_W-1:0]        outRank,
  output logic [SLOTS*IDX_W-1:0]         outIndex,
  output logic [SLOTS*PAY_W-1:0]         outPayload,
  output logic [NUM_IN-1:0]              winner
);
  logic [NUM_IN-1:0][PAY_W-1:0]  s1Pay;
  logic [NUM_IN-1:0][RANK_W-1:0] s2Rank;
  logic [NUM_IN-1:0][PAY_W-1:0]  s2Pay;
  logic [SLOTS-1:0][RANK_W-1:0]  rankD, rankQ;
  logic [SLOTS-1:0][IDX_W-1:0]   idxD, idxQ;
  logic [SLOTS-1:0][PAY_W-1:0]   payD, payQ;
  logic [NUM_IN-1:0]             winD;
  logic [SLOTS-1:0]              validQ;

  // stage 1: capture and qualify
  always_ff @(posedge clk) begin
    if (rst) begin
      s1Elig <= '0;
      s1Rank <= '0;
      s1Pay  <= '0;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        s1Elig[i] <= inValid[i] && (inRank[i*RANK_W +: RANK_W] != '0);
        s1Rank[i] <= inRank[i*RANK_W +: RANK_W];
        s1Pay[i]  <= inPayload[i*PAY_W +: PAY_W];
      end
    end
  end

  // stage 2: data aligned with the control strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      s2Rank <= '0;
      s2Pay  <= '0;
    end else begin
      s2Rank <= s1Rank;
      s2Pay  <= s1Pay;
    end
  end

  // stage 3: AND-OR output mux driven by the one-hot picks
  always_comb begin
    rankD = '0;
    idxD  = '0;
    payD  = '0;
    winD  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (selQ.pick[s][i]) begin
          rankD[s] = rankD[s] | s2Rank[i];
          idxD[s]  = idxD[s]  | IDX_W'(i);
          payD[s]  = payD[s]  | s2Pay[i];
          winD[i]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      rankQ  <= '0;
      idxQ   <= '0;
      payQ   <= '0;
      winner <= '0;
    end else begin
      validQ <= selQ.live;
      rankQ  <= rankD;
      idxQ   <= idxD;
      payQ   <= payD;
      winner <= winD;
    end
  end

  assign outValid   = validQ;
  assign outRank    = rankQ;
  assign outIndex   = idxQ;
  assign outPayload = payQ;

  a_r10_reset_clear : assert property (@(posedge clk)
    rst |=> (outValid == '0 && winner == '0));
  a_r8_winner_count : assert property (@(posedge clk) disable iff (rst)
    $countones(winner) == $countones(outValid));

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      a_r2_rank_nonzero : assert property (@(posedge clk) disable iff (rst)
        outValid[s] |-> rankQ[s] != '0);
      a_r7_idle_zero : assert property (@(posedge clk) disable iff (rst)
        !outValid[s] |-> (rankQ[s] == '0 && idxQ[s] == '0 && payQ[s] == '0));
      a_r8_winner_set : assert property (@(posedge clk) disable iff (rst)
        outValid[s] |-> winner[idxQ[s]]);
    end
    for (genvar s = 0; s + 1 < SLOTS; s++) begin : g_ord
      a_r4_descending : assert property (@(posedge clk) disable iff (rst)
        outValid[s+1] |-> (outValid[s] && rankQ[s] >= rankQ[s+1]));
    end
  endgenerate
endmodule

// File: rtl/rank_top4_sorter.sv
`timescale 1ns/1ps
module rank_top4_sorter
  import rts_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IN-1:0]         inValid,
  input  logic [NUM_IN*RANK_W-1:0]  inRank,
  input  logic [NUM_IN*PAY_W-1:0]   inPayload,
  output logic [SLOTS-1:0]          outValid,
  output logic [SLOTS*RANK_W-1:0]   outRank,
  output logic [SLOTS*IDX_W-1:0]    outIndex,
  output logic [SLOTS*PAY_W-1:0]    outPayload,
  output logic [NUM_IN-1:0]         winner
);
  sel_t                          selQ;
  logic [NUM_IN-1:0]             s1Elig;
  logic [NUM_IN-1:0][RANK_W-1:0] s1Rank;

  rts_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .s1Elig (s1Elig),
    .s1Rank (s1Rank),
    .selQ   (selQ)
  );

  rts_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inRank     (inRank),
    .inPayload  (inPayload),
    .selQ       (selQ),
    .s1Elig     (s1Elig),
    .s1Rank     (s1Rank),
    .outValid   (outValid),
    .outRank    (outRank),
    .outIndex   (outIndex),
    .outPayload (outPayload),
    .winner     (winner)
  );
endmodule

// File: tb/sim_rank_top4_sorter.sv
`timescale 1ns/1ps
module sim_rank_top4_sorter;
  import rts_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_IN-1:0]             inValid = '0;
  logic [NUM_IN-1:0][RANK_W-1:0] inRank = '0;
  logic [NUM_IN-1:0][PAY_W-1:0]  inPayload = '0;
  logic [SLOTS-1:0]              outValid;
  logic [SLOTS*RANK_W-1:0]       outRank;
  logic [SLOTS*IDX_W-1:0]        outIndex;
  logic [SLOTS*PAY_W-1:0]        outPayload;
  logic [NUM_IN-1:0]             winner;

  always #2 clk = ~clk;

  rank_top4_sorter u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inRank(inRank),
    .inPayload(inPayload), .outValid(outValid), .outRank(outRank),
    .outIndex(outIndex), .outPayload(outPayload), .winner(winner)
  );

  typedef struct packed {
    logic [SLOTS-1:0]             v;
    logic [SLOTS-1:0][RANK_W-1:0] r;
    logic [SLOTS-1:0][IDX_W-1:0]  x;
    logic [SLOTS-1:0][PAY_W-1:0]  p;
    logic [NUM_IN-1:0]            w;
  } exp_t;

  exp_t  expQ[$];
  int    dueQ[$];
  string tagQ[$];
  int edgeCnt = 0;
  int checks = 0;
  int failures = 0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [NUM_IN-1:0] v,
                                 input logic [NUM_IN-1:0][RANK_W-1:0] r,
                                 input logic [NUM_IN-1:0][PAY_W-1:0] p);
    exp_t e;
    logic [NUM_IN-1:0] taken;
    e = '0;
    taken = '0;
    for (int s = 0; s < SLOTS; s++) begin
      int best;
      best = -1;
      for (int i = 0; i < NUM_IN; i++)
        if (!taken[i] && v[i] && r[i] != 0)
          if (best < 0 || r[i] > r[best]) best = i;
      if (best >= 0) begin
        taken[best] = 1'b1;
        e.v[s] = 1'b1;
        e.r[s] = r[best];
        e.x[s] = IDX_W'(best);
        e.p[s] = p[best];
      end
    end
    e.w = taken;
    return e;
  endfunction

  // driver: one crossing per cycle, expected result due three edges later (R9)
  task automatic drive(input logic [NUM_IN-1:0] v,
                       input logic [NUM_IN-1:0][RANK_W-1:0] r,
                       input logic [NUM_IN-1:0][PAY_W-1:0] p,
                       input string tag);
    @(posedge clk);
    #1;
    inValid = v;
    inRank = r;
    inPayload = p;
    expQ.push_back(model(v, r, p));
    dueQ.push_back(edgeCnt + 3);
    tagQ.push_back(tag);
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (dueQ.size() > 0 && dueQ[0] <= edgeCnt) begin
      exp_t e;
      string t;
      int d;
      e = expQ.pop_front();
      d = dueQ.pop_front();
      t = tagQ.pop_front();
      chk(d == edgeCnt, t, "R9 latency", 64'(edgeCnt), 64'(d));
      chk(outValid == e.v, t, "R3 valid", 64'(outValid), 64'(e.v));
      chk(outRank == e.r, t, "R4 R7 rank", 64'(outRank), 64'(e.r));
      chk(outIndex == e.x, t, "R5 R6 index", 64'(outIndex), 64'(e.x));
      chk(outPayload == e.p, t, "R6 R7 payload", 64'(outPayload), 64'(e.p));
      chk(winner == e.w, t, "R8 winner", 64'(winner), 64'(e.w));
    end
  end

  task automatic resetCheck(input string tag);
    @(posedge clk);
    #1;
    rst = 1'b1;
    expQ.delete();
    dueQ.delete();
    tagQ.delete();
    for (int i = 0; i < NUM_IN; i++) begin
      inValid[i] = 1'b1;
      inRank[i] = RANK_W'(i + 1);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(outValid == '0, tag, "R10 valid", 64'(outValid), 64'd0);
    chk(winner == '0, tag, "R10 winner", 64'(winner), 64'd0);
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NUM_IN-1:0]             v;
    logic [NUM_IN-1:0][RANK_W-1:0] r;
    logic [NUM_IN-1:0][PAY_W-1:0]  p;

    resetCheck("R10 initial reset");

    for (int i = 0; i < NUM_IN; i++) p[i] = PAY_W'(16'hA500 + i * 16'h0101);

    // nothing valid
    v = '0; r = '0;
    drive(v, r, p, "R7 empty crossing");

    // single candidate: source 11, candidate 2 is input 35 (R1)
    v = '0; r = '0;
    v[35] = 1'b1; r[35] = 7'd127;
    drive(v, r, p, "R1 R7 single last input");

    // high ranks that are invalid, and a valid rank 0
    v = '0; r = '0;
    r[3] = 7'd120; r[9] = 7'd119;
    v[4] = 1'b1; r[4] = 7'd0;
    v[20] = 1'b1; r[20] = 7'd5;
    v[21] = 1'b1; r[21] = 7'd6;
    drive(v, r, p, "R2 ineligible ignored");

    // all equal ranks
    v = '1;
    for (int i = 0; i < NUM_IN; i++) r[i] = 7'd50;
    drive(v, r, p, "R5 all equal");

    // ties at the top
    v = '1;
    for (int i = 0; i < NUM_IN; i++) r[i] = 7'd20;
    r[30] = 7'd90; r[5] = 7'd90; r[17] = 7'd90;
    drive(v, r, p, "R5 top ties");

    // strictly increasing ranks
    v = '1;
    for (int i = 0; i < NUM_IN; i++) r[i] = RANK_W'(i + 1);
    drive(v, r, p, "R3 R4 ascending field");

    // back-to-back random crossings
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        v[i] = ($urandom % 4) != 0;
        r[i] = RANK_W'((n % 2 == 0) ? ($urandom % 8) : $urandom);
        p[i] = PAY_W'($urandom);
      end
      drive(v, r, p, "R9 random stream");
    end

    resetCheck("R10 mid-run reset");

    v = '1;
    for (int i = 0; i < NUM_IN; i++) r[i] = RANK_W'(NUM_IN - i);
    drive(v, r, p, "R4 descending field after reset");

    @(posedge clk);
    #1;
    inValid = '0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(dueQ.size() == 0, "R9", "drain", 64'(dueQ.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule